// File: doc/BRIEF.md
# Asynchronous SRAM controller

This block is a clocked front end for an external asynchronous static RAM. The RAM has two chip enables (one active low, one active high), an active-low output enable, an active-low write enable, an address bus, and separate buses for write data and read data. A host issues single-word reads and writes through a valid/ready port. The controller then steps the RAM strobes through a fixed sequence of phases, and every phase lasts a whole number of clock cycles.

The length of each phase is worked out when the block is elaborated. The controller takes the RAM timing figures in nanoseconds and the clock period, converts each figure to cycles by rounding up, and never uses less than one cycle. During a write the output enable is held high. During a read the write-data drivers are released. After every read there are recovery cycles, and these cover the longest time the RAM may keep driving its outputs once it has been deselected. Read data is sampled on the last cycle of the access window and is returned to the host with a single-cycle valid pulse.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `req_ready` is 1 and `rsp_valid` is 0. In the same cycles the write strobe, the read strobe and the write-data driver enable are all inactive: `mem_we_n`=1, `mem_oe_n`=1 and `mem_dout_en`=0.
- R2: Each phase length is the ceiling of (time in ns / `CLK_NS`), with a floor of 1 cycle. The write-strobe length is the largest of the converted write-pulse, chip-select-to-end, address-to-end and data-setup times. The hold length is the larger of 1 and the converted write-cycle time minus the strobe length. The read window is the largest of the converted address, chip-enable and output-enable access times. The recovery length is the larger of the converted output-enable and chip-enable release times.
- R3: A write holds `mem_we_n` low for exactly the write-strobe length of consecutive cycles, and the chip enables stay active throughout (`mem_ce_n`=0, `mem_ce2`=1). This is followed by the hold length with `mem_we_n` high.
- R4: `mem_oe_n` never goes low during a write. During a read it is low for exactly the read-window length.
- R5: The address and write data are captured when the request is accepted. They stay stable on `mem_addr` and `mem_dout` for as long as `mem_we_n` is low, so a change on `req_wdata` after acceptance has no effect on the stored word.
- R6: `mem_dout_en` is 1 only during the strobe and hold phases of a write, and never while `mem_oe_n` is low. After a read, the first write that drives data sees at least the recovery length of cycles with `mem_oe_n` high.
- R7: `mem_din` is sampled on the last cycle of the read window. `rsp_valid` is high for exactly one cycle, the first cycle after that window, and carries the sampled word on `rsp_rdata`.
- R8: `req_ready` goes low in the cycle after acceptance and stays low for (strobe + hold) cycles after a write and (read window + recovery) cycles after a read.
- R9: In idle the chip is deselected (`mem_ce_n`=1, `mem_ce2`=0). The chip is also deselected during read recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; request accepted when valid and ready are both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write word |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_rdata | output | DW | Read word |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_ce2 | output | 1 | RAM chip enable, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_addr | output | AW | RAM address |
| mem_dout | output | DW | Write data towards the RAM |
| mem_dout_en | output | 1 | Driver enable for `mem_dout` |
| mem_din | input | DW | Read data from the RAM |

## Verification
A wrong phase counter value changes how long `mem_we_n` or `mem_oe_n` stays low. It also moves the cycle in which `req_ready` returns, so it shows within one access. A wrong capture point gives a wrong `rsp_rdata`, because the memory model in the bench only presents valid data late in the read window. A missing or short recovery phase shortens the gap between the end of a read strobe and the next enable of the data driver, and this shows on the first write after a read. Address or data that is not held steady corrupts the stored word, and a later read-back makes that visible.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WSTRB = 3'd1,
    PH_WHOLD = 3'd2,
    PH_RWIN  = 3'd3,
    PH_RREC  = 3'd4
  } phase_t;

  // nanoseconds to whole cycles, rounded up, at least one cycle
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int c;
    c = t_ns / clk_ns;
    if ((t_ns % clk_ns) != 0) c = c + 1;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int WACT  = 2,
  parameter int WHOLD = 1,
  parameter int RACT  = 2,
  parameter int RTA   = 1,
  parameter int CW    = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  output phase_t phase,
  output logic   req_ready,
  output logic   ev_accept,
  output logic   ev_capture
);

  localparam logic [CW-1:0] WACT_M1  = CW'(WACT - 1);
  localparam logic [CW-1:0] WHOLD_M1 = CW'(WHOLD - 1);
  localparam logic [CW-1:0] RACT_M1  = CW'(RACT - 1);
  localparam logic [CW-1:0] RTA_M1   = CW'(RTA - 1);

  logic [CW-1:0] cnt;
  logic          last;

  assign last       = (cnt == '0);
  assign req_ready  = (phase == PH_IDLE);
  assign ev_accept  = req_valid && req_ready;
  assign ev_capture = (phase == PH_RWIN) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            phase <= req_write ? PH_WSTRB : PH_RWIN;
            cnt   <= req_write ? WACT_M1 : RACT_M1;
          end
        end
        PH_WSTRB: begin
          if (last) begin
            phase <= PH_WHOLD;
            cnt   <= WHOLD_M1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_WHOLD: begin
          if (last) phase <= PH_IDLE;
          else      cnt   <= cnt - 1'b1;
        end
        PH_RWIN: begin
          if (last) begin
            phase <= PH_RREC;
            cnt   <= RTA_M1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_RREC: begin
          if (last) phase <= PH_IDLE;
          else      cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        phase,
  input  logic          ev_accept,
  input  logic          ev_capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_din,
  output logic          mem_ce_n,
  output logic          mem_ce2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_en,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          sel_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (ev_accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= ev_capture;
      if (ev_capture) rsp_rdata <= mem_din;
    end
  end

  assign sel_on      = (phase == PH_WSTRB) || (phase == PH_WHOLD) || (phase == PH_RWIN);
  assign mem_ce_n    = !sel_on;
  assign mem_ce2     = sel_on;
  assign mem_we_n    = (phase != PH_WSTRB);
  assign mem_oe_n    = (phase != PH_RWIN);
  assign mem_dout_en = (phase == PH_WSTRB) || (phase == PH_WHOLD);
  assign mem_addr    = addr_q;
  assign mem_dout    = wdata_q;

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int CLK_NS  = 10,
  parameter int T_WC    = 20,
  parameter int T_PWE   = 13,
  parameter int T_SCE   = 18,
  parameter int T_AW    = 15,
  parameter int T_SD    = 10,
  parameter int T_HD    = 0,
  parameter int T_HA    = 0,
  parameter int T_AA    = 20,
  parameter int T_ACE   = 20,
  parameter int T_DOE   = 8,
  parameter int T_HZOE  = 8,
  parameter int T_HZCE  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_ce_n,
  output logic          mem_ce2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_en,
  input  logic [DW-1:0] mem_din
);

  localparam int WACT  = imax(imax(ns_to_cyc(T_PWE, CLK_NS), ns_to_cyc(T_SCE, CLK_NS)),
                              imax(ns_to_cyc(T_AW, CLK_NS),  ns_to_cyc(T_SD, CLK_NS)));
  localparam int WHOLD = imax(imax(ns_to_cyc(T_HD, CLK_NS), ns_to_cyc(T_HA, CLK_NS)),
                              ns_to_cyc(T_WC, CLK_NS) - WACT);
  localparam int RACT  = imax(imax(ns_to_cyc(T_AA, CLK_NS), ns_to_cyc(T_ACE, CLK_NS)),
                              ns_to_cyc(T_DOE, CLK_NS));
  localparam int RTA   = imax(ns_to_cyc(T_HZOE, CLK_NS), ns_to_cyc(T_HZCE, CLK_NS));
  localparam int CNT_MAX = imax(imax(WACT, WHOLD), imax(RACT, RTA));
  localparam int CW      = cnt_bits(CNT_MAX + 1);

  phase_t phase;
  logic   ev_accept;
  logic   ev_capture;

  sram_ctl_seq #(
    .WACT (WACT),
    .WHOLD(WHOLD),
    .RACT (RACT),
    .RTA  (RTA),
    .CW   (CW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .phase     (phase),
    .req_ready (req_ready),
    .ev_accept (ev_accept),
    .ev_capture(ev_capture)
  );

  sram_ctl_pins #(
    .AW(AW),
    .DW(DW)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .ev_accept  (ev_accept),
    .ev_capture (ev_capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_din    (mem_din),
    .mem_ce_n   (mem_ce_n),
    .mem_ce2    (mem_ce2),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_addr   (mem_addr),
    .mem_dout   (mem_dout),
    .mem_dout_en(mem_dout_en),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int WACT = 1,
  parameter int RTA  = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_ce_n,
  input logic          mem_ce2,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dout,
  input logic          mem_dout_en,
  input logic          ev_accept,
  input logic          ev_capture
);

  int we_lo_cnt;
  int oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= 0;
      oe_hi_cnt <= RTA;
    end else begin
      we_lo_cnt <= mem_we_n ? 0 : we_lo_cnt + 1;
      if (!mem_oe_n)          oe_hi_cnt <= 0;
      else if (oe_hi_cnt < RTA) oe_hi_cnt <= oe_hi_cnt + 1;
    end
  end

  AST_WE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_ce2)); // R3
  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt >= WACT)); // R3
  AST_NO_READ_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R4
  AST_WR_BUS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout))); // R5
  AST_DRIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> mem_oe_n); // R6
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dout_en) |-> (oe_hi_cnt >= RTA)); // R6
  AST_CAPTURE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |=> rsp_valid); // R7
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready); // R8

endmodule

bind sram_ctl sram_ctl_chk #(
  .AW(AW), .DW(DW), .WACT(WACT), .RTA(RTA)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_ce_n   (mem_ce_n),
  .mem_ce2    (mem_ce2),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_addr   (mem_addr),
  .mem_dout   (mem_dout),
  .mem_dout_en(mem_dout_en),
  .ev_accept  (ev_accept),
  .ev_capture (ev_capture)
);

// File: tb/sram_ctl_test.sv
module sram_ctl_test;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CLK_NS = 10;

  // expected phase lengths, restated: round up, floor of one
  function automatic int up(input int t);
    int r;
    r = (t + CLK_NS - 1) / CLK_NS;
    return (r == 0) ? 1 : r;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a >= b) ? a : b;
  endfunction

  localparam int E_WACT  = mx(mx(up(13), up(18)), mx(up(15), up(10)));
  localparam int E_WHOLD = mx(mx(up(0), up(0)), up(20) - E_WACT);
  localparam int E_RACT  = mx(mx(up(20), up(20)), up(8));
  localparam int E_RTA   = mx(up(8), up(10));

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dout_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dout;
  logic [DW-1:0] mem_din;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sram_ctl #(.AW(AW), .DW(DW), .CLK_NS(CLK_NS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
    .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din)
  );

  // memory model: data valid only late in the read window
  logic [DW-1:0] mem_arr [0:(1<<AW)-1];
  logic rd_on, wr_on;
  int   rd_age = 0;
  assign rd_on = !mem_ce_n && mem_ce2 && !mem_oe_n;
  assign wr_on = !mem_ce_n && mem_ce2 && !mem_we_n;
  always @(posedge clk) rd_age <= rd_on ? rd_age + 1 : 0;
  assign mem_din = (rd_on && rd_age >= E_RACT - 1) ? mem_arr[mem_addr] : ~mem_arr[mem_addr];
  always @(negedge wr_on) mem_arr[mem_addr] = mem_dout_en ? mem_dout : ~mem_dout;

  // turnaround monitor
  int  oe_hi_run = 0;
  int  last_gap = -1;
  bit  prev_den = 1'b0;
  always @(negedge clk) begin
    if (mem_dout_en && !prev_den) last_gap = oe_hi_run;
    oe_hi_run = mem_oe_n ? oe_hi_run + 1 : 0;
    prev_den = mem_dout_en;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int r_busy, r_we_lo, r_oe_lo, r_rsp_cnt, r_rsp_at, r_bad, r_unsteady;
  logic [DW-1:0] r_rdata;

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [AW-1:0] a0;
    logic [DW-1:0] d0;
    bit seen_we;
    int cyc;
    r_busy = 0; r_we_lo = 0; r_oe_lo = 0; r_rsp_cnt = 0; r_rsp_at = -1;
    r_bad = 0; r_unsteady = 0; r_rdata = '0; seen_we = 1'b0; a0 = '0; d0 = '0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~d; req_addr = ~a;
    cyc = 1;
    while (!req_ready && cyc < 100) begin
      r_busy++;
      if (!mem_we_n) begin
        r_we_lo++;
        if (!seen_we) begin a0 = mem_addr; d0 = mem_dout; seen_we = 1'b1; end
        else if (mem_addr != a0 || mem_dout != d0) r_unsteady++;
        if (mem_ce_n || !mem_ce2) r_bad++;
      end
      if (!mem_oe_n) r_oe_lo++;
      if (mem_dout_en && !mem_oe_n) r_bad++;
      if (rsp_valid) begin r_rsp_cnt++; r_rsp_at = cyc; r_rdata = rsp_rdata; end
      @(negedge clk);
      cyc++;
    end
    if (rsp_valid) r_rsp_cnt++;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    chk(mem_we_n && mem_oe_n && !mem_dout_en, "R1 strobes idle in reset",
        {mem_we_n, mem_oe_n, mem_dout_en}, 3'b110);
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_we_n && mem_oe_n && !mem_dout_en && !rsp_valid,
        "R1 idle after reset", {req_ready, mem_we_n, mem_oe_n, mem_dout_en, rsp_valid}, 5'b11100);
    chk(mem_ce_n && !mem_ce2, "R9 deselected in idle", {mem_ce_n, mem_ce2}, 2'b10);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    do_op(1'b1, a, d);
    chk(r_busy == E_WACT + E_WHOLD, "R2 R8 write busy cycles", r_busy, E_WACT + E_WHOLD);
    chk(r_we_lo == E_WACT, "R3 write strobe cycles", r_we_lo, E_WACT);
    chk(r_oe_lo == 0, "R4 oe low during write", r_oe_lo, 0);
    chk(r_bad == 0, "R6 drive or select conflict", r_bad, 0);
    chk(r_unsteady == 0, "R5 bus change under strobe", r_unsteady, 0);
    chk(mem_arr[a] == d, "R5 stored word", mem_arr[a], d);
    chk(mem_ce_n && !mem_ce2, "R9 deselected after write", {mem_ce_n, mem_ce2}, 2'b10);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    do_op(1'b0, a, '0);
    chk(r_busy == E_RACT + E_RTA, "R8 read busy cycles", r_busy, E_RACT + E_RTA);
    chk(r_oe_lo == E_RACT, "R4 read window cycles", r_oe_lo, E_RACT);
    chk(r_we_lo == 0, "R3 no strobe in read", r_we_lo, 0);
    chk(r_rsp_cnt == 1, "R7 rsp pulse count", r_rsp_cnt, 1);
    chk(r_rsp_at == E_RACT + 1, "R7 rsp cycle", r_rsp_at, E_RACT + 1);
    chk(r_rdata == exp, "R7 read data", r_rdata, exp);
  endtask

  task automatic t_turnaround();
    t_read(8'h10, mem_arr[8'h10]);
    t_write(8'h11, 16'h5A5A);
    chk(last_gap == E_RTA + 1, "R6 turnaround gap", last_gap, E_RTA + 1);
    chk(last_gap >= E_RTA, "R6 gap covers recovery", last_gap, E_RTA);
  endtask

  task automatic t_patterns();
    t_write(8'h00, 16'h0000);
    t_write(8'hFF, 16'hFFFF);
    t_write(8'h3C, 16'hA5C3);
    t_read(8'h00, 16'h0000);
    t_read(8'hFF, 16'hFFFF);
    t_read(8'h3C, 16'hA5C3);
    t_read(8'h3C, 16'hA5C3);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem_arr[i] = DW'(i * 16'h0137 + 16'h2001);
    repeat (3) @(negedge clk);
    t_reset();
    t_write(8'h42, 16'hBEEF);
    t_read(8'h42, 16'hBEEF);
    t_read(8'h07, DW'(7 * 16'h0137 + 16'h2001));
    t_turnaround();
    t_patterns();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule